// File: doc/BRIEF.md
# Pulse-Burst Operating Mode Decoder

This block turns a single asynchronous control wire into a power enable and a two-bit operating mode. The controller sends a short burst of high pulses. Each qualified rising edge in the burst advances a saturating mode index. The first edge after shutdown also raises `enable`. When the line then stays high for the latch window, the index is committed to `mode`, and `mode_latched` pulses for one cycle. From then on, further pulses are ignored. Holding the line low for the shutdown window drops `enable` and clears `mode`. A new burst after that selects a new mode.

The wire passes through a two-flop synchronizer. A run timer then measures how many cycles the synchronized level has been steady. Every timing window is a parameter in clock cycles. The defaults assume a 10 MHz clock: 8 cycles minimum high width, and 3000 cycles (300 µs) for both the latch and shutdown windows.

The controller has four states:
- `ST_OFF`: shut down.
- `ST_HIGH`: the line is high inside a burst.
- `ST_LOW`: the line is low inside a burst.
- `ST_ON`: the mode is committed.

The transitions are:
- OFF→HIGH on a qualified high.
- HIGH→LOW when the line falls.
- LOW→HIGH on a qualified high, which also increments the index.
- HIGH→ON when the latch window expires.
- LOW→OFF or ON→OFF when the shutdown window expires.

Top module: `pbm_mode_decoder`

## Requirements
- R1: After reset, `enable` is 0, `mode` is 0 and `mode_latched` is 0.
- R2: A high level held for at least MIN_W synchronized cycles while shut down raises `enable`, before any mode is committed.
- R3: With N qualified rising edges (N = 1 to 4), once the line has been high for LATCH_CYC cycles, `mode` becomes N-1 (00 is mode 1, 11 is mode 4). `mode_latched` is high for exactly one cycle, with the same timing.
- R4: More than four qualified edges in a burst give `mode` = 11. The index saturates.
- R5: A high pulse shorter than MIN_W synchronized cycles is not counted and does not raise `enable`.
- R6: During a burst, a low shorter than SHDN_CYC cycles is ignored and counting continues. After the latch, a low of that length leaves `enable` set.
- R7: After the mode is committed, further pulses change neither `mode` nor `enable`, and produce no `mode_latched`.
- R8: A low held for SHDN_CYC cycles, either after the latch or inside a burst, clears `enable` and `mode`.
- R9: After a shutdown, a fresh burst selects a new mode according to R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_async | input | 1 | Asynchronous single-wire control line |
| enable | output | 1 | Device enable |
| mode | output | MW (2) | Committed operating mode index |
| mode_latched | output | 1 | One-cycle strobe when a mode is committed |

## Verification
A rising edge on `ctl_async` reaches the run timer three clock edges later. The commit strobe therefore appears about LATCH_CYC+3 cycles after the final rising edge. The bench records the cycle of each strobe and requires it to fall in a window from LATCH_CYC to LATCH_CYC+8 cycles. It then samples `mode` well after that window.

Shutdown is likewise due about SHDN_CYC+3 cycles after the fall. The bench checks `enable` still high at SHDN_CYC-10 cycles and low at SHDN_CYC+10 cycles. Glitch and mid-burst low tests keep at least a few cycles of margin from each threshold.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2,
        ST_ON   = 2'd3
    } pbm_state_t;
endpackage

// File: rtl/pbm_sync.sv
module pbm_sync #(
    parameter int CAP = 3000,
    localparam int RW = $clog2(CAP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          async_in,
    output logic          level,
    output logic [RW-1:0] run
);
    localparam logic [RW-1:0] RUN_MAX = RW'(CAP);

    logic s1, s2, lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1    <= 1'b0;
            s2    <= 1'b0;
            lvl_q <= 1'b0;
            run   <= '0;
        end else begin
            s1    <= async_in;
            s2    <= s1;
            lvl_q <= s2;
            if (s2 != lvl_q)
                run <= '0;
            else if (run != RUN_MAX)
                run <= run + 1'b1;
        end
    end

    assign level = lvl_q;

    // R5
    run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |-> (run == '0));
endmodule

// File: rtl/pbm_sat_ctr.sv
module pbm_sat_ctr #(
    parameter int N = 4,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] idx
);
    localparam logic [W-1:0] LAST = W'(N - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx <= '0;
        else if (clr)
            idx <= '0;
        else if (inc && idx != LAST)
            idx <= idx + 1'b1;
    end

    // R4
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == LAST && inc && !clr) |=> (idx == LAST));
endmodule

// File: rtl/pbm_mode_decoder.sv
module pbm_mode_decoder
    import pbm_pkg::*;
#(
    parameter int N_MODES   = 4,
    parameter int MIN_W     = 8,
    parameter int LATCH_CYC = 3000,
    parameter int SHDN_CYC  = 3000,
    localparam int MW = (N_MODES > 1) ? $clog2(N_MODES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_async,
    output logic          enable,
    output logic [MW-1:0] mode,
    output logic          mode_latched
);
    localparam int CAP = (LATCH_CYC > SHDN_CYC) ? LATCH_CYC : SHDN_CYC;
    localparam int RW  = $clog2(CAP + 1);
    localparam logic [RW-1:0] HI_TH  = RW'(MIN_W - 1);
    localparam logic [RW-1:0] LAT_TH = RW'(LATCH_CYC - 1);
    localparam logic [RW-1:0] OFF_TH = RW'(SHDN_CYC - 1);

    logic          level;
    logic [RW-1:0] run;
    logic [MW-1:0] idx;
    logic          hi_ok, latch_ok, off_ok, ctr_clr, ctr_inc, commit;
    pbm_state_t    state, next;

    pbm_sync #(.CAP(CAP)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ctl_async),
        .level    (level),
        .run      (run)
    );

    assign hi_ok    = level && (run >= HI_TH);
    assign latch_ok = level && (run >= LAT_TH);
    assign off_ok   = !level && (run >= OFF_TH);

    always_comb begin
        next = state;
        unique case (state)
            ST_OFF:  if (hi_ok) next = ST_HIGH;
            ST_HIGH: if (latch_ok) next = ST_ON;
                     else if (!level) next = ST_LOW;
            ST_LOW:  if (off_ok) next = ST_OFF;
                     else if (hi_ok) next = ST_HIGH;
            ST_ON:   if (off_ok) next = ST_OFF;
        endcase
    end

    assign ctr_clr = (state == ST_OFF);
    assign ctr_inc = (state == ST_LOW) && (next == ST_HIGH);
    assign commit  = (state == ST_HIGH) && (next == ST_ON);

    pbm_sat_ctr #(.N(N_MODES)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctr_clr),
        .inc   (ctr_inc),
        .idx   (idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_OFF;
        else
            state <= next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable       <= 1'b0;
            mode         <= '0;
            mode_latched <= 1'b0;
        end else begin
            enable       <= (next != ST_OFF);
            mode_latched <= commit;
            if (commit)
                mode <= idx;
            else if (next == ST_OFF)
                mode <= '0;
        end
    end

    // R3
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_latched |=> !mode_latched);

    // R3
    strobe_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_latched |-> (enable && state == ST_ON));

    // R7
    on_mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ON && $past(state) == ST_ON) |-> $stable(mode));

    // R8
    off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && $past(state) != ST_OFF) |-> (!enable && mode == '0));
endmodule

// File: tb/pbm_mode_decoder_tb.sv
module pbm_mode_decoder_tb;
    localparam int MIN_W = 4;
    localparam int LATCH = 40;
    localparam int SHDN  = 60;
    localparam int PW    = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl = 1'b0;
    logic       enable;
    logic [1:0] mode;
    logic       mode_latched;

    int cyc = 0;
    int stb_n = 0;
    int stb_cyc = 0;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pbm_mode_decoder #(
        .N_MODES(4), .MIN_W(MIN_W), .LATCH_CYC(LATCH), .SHDN_CYC(SHDN)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_async    (ctl),
        .enable       (enable),
        .mode         (mode),
        .mode_latched (mode_latched)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && mode_latched) begin
            stb_n   = stb_n + 1;
            stb_cyc = cyc;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic burst(input int n, input int lo_len);
        int t0;
        int exp_mode;
        stb_n = 0;
        for (int i = 0; i < n; i++) begin
            ctl = 1'b1;
            if (i < n - 1) begin
                idle(PW);
                ctl = 1'b0;
                idle(lo_len);
            end
        end
        t0 = cyc;
        idle(LATCH + 12);
        exp_mode = ((n > 4) ? 4 : n) - 1;
        check(stb_n == 1, "R3 strobe count", stb_n, 1);
        check((stb_cyc - t0) >= LATCH && (stb_cyc - t0) <= LATCH + 8,
              "R3 strobe latency", stb_cyc - t0, LATCH + 3);
        check(int'(mode) == exp_mode, (n > 4) ? "R4 saturated mode" : "R3 R9 mode",
              int'(mode), exp_mode);
        check(enable == 1'b1, "R2 enable after burst", int'(enable), 1);
    endtask

    task automatic shutdown();
        ctl = 1'b0;
        idle(SHDN - 10);
        check(enable == 1'b1, "R6 short low keeps enable", int'(enable), 1);
        idle(20);
        check(enable == 1'b0, "R8 shutdown enable", int'(enable), 0);
        check(mode == 2'd0, "R8 shutdown mode", int'(mode), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(5);
        check(enable == 1'b0, "R1 reset enable", int'(enable), 0);
        check(mode == 2'd0, "R1 reset mode", int'(mode), 0);
        check(mode_latched == 1'b0, "R1 reset strobe", int'(mode_latched), 0);
        rst_n = 1'b1;
        idle(5);

        // R5: glitch while shut down
        ctl = 1'b1;
        idle(2);
        ctl = 1'b0;
        idle(20);
        check(enable == 1'b0, "R5 glitch no enable", int'(enable), 0);

        // R2: enable rises before latch
        stb_n = 0;
        ctl = 1'b1;
        idle(12);
        check(enable == 1'b1, "R2 early enable", int'(enable), 1);
        check(stb_n == 0, "R2 no early strobe", stb_n, 0);
        idle(LATCH + 10);
        check(stb_n == 1 && mode == 2'd0, "R3 single edge mode", int'(mode), 0);
        shutdown();

        // R3 R4 R9: sweep of edge counts
        for (int n = 1; n <= 6; n++) begin
            burst(n, PW);
            shutdown();
        end

        // R6: long-but-short-of-shutdown lows inside a burst
        burst(3, 40);
        shutdown();

        // R5: glitch inside a burst is not counted
        stb_n = 0;
        ctl = 1'b1; idle(PW);
        ctl = 1'b0; idle(PW);
        ctl = 1'b1; idle(2);
        ctl = 1'b0; idle(PW);
        ctl = 1'b1; idle(LATCH + 12);
        check(mode == 2'd1, "R5 burst glitch ignored", int'(mode), 1);

        // R7: pulses after latch are ignored
        stb_n = 0;
        for (int i = 0; i < 3; i++) begin
            ctl = 1'b0; idle(PW);
            ctl = 1'b1; idle(PW);
        end
        idle(LATCH + 12);
        check(mode == 2'd1, "R7 mode unchanged", int'(mode), 1);
        check(stb_n == 0, "R7 no strobe", stb_n, 0);
        check(enable == 1'b1, "R7 enable held", int'(enable), 1);
        shutdown();

        // R8: shutdown from inside a burst
        stb_n = 0;
        ctl = 1'b1; idle(PW);
        ctl = 1'b0; idle(PW);
        ctl = 1'b1; idle(PW);
        ctl = 1'b0; idle(SHDN + 10);
        check(enable == 1'b0, "R8 burst shutdown", int'(enable), 0);
        check(stb_n == 0, "R8 no strobe", stb_n, 0);

        // R9: recovery after shutdown
        burst(2, PW);
        shutdown();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule